// File: doc/BRIEF.md
# Pre-retirement late execution and prediction check unit

This block sits between the out-of-order core and retirement in a pipeline that predicts instruction results. Every instruction that received a predicted value is pushed, in program order, into an internal queue when it is predicted. Near retirement the unit drains the oldest queue entries. For a simple single-cycle ALU instruction that was predicted and therefore never sent to the out-of-order core, it reads the two source operands from the register file and computes the result itself. For an instruction the core already executed, it reads back the destination register. In both cases the result is compared with the prediction.

Register-file reads come from a small shared pool of ports. A re-executed entry takes two reads and a check-only entry takes one. Each cycle the unit takes the longest run of oldest entries that fits in the pool, the lane count, and the number of entries the reorder buffer says may retire. For each entry it reports the result and whether the prediction held, which goes both to commit and to the predictor trainer. On the first wrong prediction it stops at that entry, lets the entry commit with the computed value, requests a squash that names its tag, and drops every younger queued entry.

Top module: `late_validate_unit`

## Requirements
- R1: A push is accepted when `pred_valid` is high, `pred_full` is low and no flush happens in that cycle. `pred_full` is high exactly when DEPTH (default 32) entries are held, and a push while it is high changes nothing.
- R2: Results leave in the order the entries were pushed. Lane 0 carries the oldest entry of a cycle, and later lanes carry the entries that follow it.
- R3: An entry with `pred_exec`=1 costs two register-file reads and an entry with `pred_exec`=0 costs one. The reads taken in one cycle never exceed PORTS (default 4).
- R4: The entries taken in a cycle are the longest prefix of the oldest entries whose running read cost fits in PORTS. This prefix is also capped by LANES (default 8), by the queue occupancy and by `rob_ready_cnt`. Selection stops at the first entry that does not fit.
- R5: A late-executed entry computes from read data A (first read) and B (second read) using `pred_op`: 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 unsigned A<B as 0/1, 6 A shifted left by the low log2(XLEN) bits of B, 7 B.
- R6: A check-only entry takes as its result the value read from register `pred_dst`.
- R7: Each reported lane shows the result in `res_value` and sets `res_correct` high exactly when the result equals the predicted value.
- R8: When a taken entry mismatches, lanes up to and including the first mismatching one are reported and later lanes are not. That entry is reported with `res_correct`=0 and its computed value, and `squash_req` is raised with `squash_tag` equal to its tag.
- R9: In a squash cycle all younger queued entries are discarded and any push in that cycle is dropped, so none of them ever produces a result.
- R10: Results of the entries taken in a cycle appear on the lane outputs on the next clock edge, and `res_valid` is always a contiguous run starting at lane 0.
- R11: After reset the queue is empty, `pred_full` is low, and no lane or squash is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Push a predicted instruction |
| pred_exec | input | 1 | 1: late execute here, 0: check only |
| pred_op | input | 3 | ALU operation code (R5) |
| pred_src_a | input | AREG | First source register |
| pred_src_b | input | AREG | Second source register |
| pred_dst | input | AREG | Destination register |
| pred_value | input | XLEN | Predicted result |
| pred_tag | input | TAGW | Instruction tag |
| pred_full | output | 1 | Queue full, pushes are refused |
| rob_ready_cnt | input | clog2(LANES+1) | Oldest entries allowed to retire |
| rf_raddr | output | PORTS x AREG | Register-file read addresses |
| rf_rdata | input | PORTS x XLEN | Register-file read data, same cycle |
| res_valid | output | LANES | Lane reports a result |
| res_correct | output | LANES | Prediction held |
| res_value | output | LANES x XLEN | Result to commit |
| res_tag | output | LANES x TAGW | Tag of the reported entry |
| squash_req | output | 1 | Squash request |
| squash_tag | output | TAGW | Tag of the mispredicted entry |

## Verification
A squash and a new prediction push can land in the same cycle, so the flush has to win over the write pointer. The bench fills the queue with a mispredicted head entry while retirement is held off. It then opens retirement with a count of one and, on that same clock edge, pushes a further entry. The squash must name the head's tag and report exactly one lane. Neither the younger queued entries nor the pushed one may produce a result in the cycles that follow, even with retirement fully open. A scoreboard model of greedy port-budget selection also judges the lane count of every cycle.

// File: rtl/lvu_pkg.sv
package lvu_pkg;
   localparam int OPW = 3;
   typedef enum logic [OPW-1:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_LTU  = 3'd5,
      OP_SHL  = 3'd6,
      OP_PASS = 3'd7
   } alu_op_e;
endpackage

// File: rtl/lvu_fifo.sv
module lvu_fifo #(
   parameter int WIDTH = 64,
   parameter int DEPTH = 32,
   parameter int LANES = 8,
   localparam int IW   = $clog2(DEPTH),
   localparam int PTRW = IW + 1,
   localparam int CW   = $clog2(LANES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic [WIDTH-1:0]            push_data,
   input  logic [CW-1:0]               pop_cnt,
   input  logic                        flush,
   output logic [LANES-1:0][WIDTH-1:0] win,
   output logic [PTRW-1:0]             occ,
   output logic                        full
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTRW-1:0]  rd_ptr, wr_ptr, rd_next;
   logic             do_push;

   assign occ     = wr_ptr - rd_ptr;
   assign full    = (occ == PTRW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign rd_next = rd_ptr + PTRW'(pop_cnt);

   always_comb begin
      for (int i = 0; i < LANES; i++)
         win[i] = mem[rd_ptr[IW-1:0] + IW'(i)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
      end else begin
         rd_ptr <= rd_next;
         if (flush)
            wr_ptr <= rd_next;
         else if (do_push)
            wr_ptr <= wr_ptr + PTRW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push)
         mem[wr_ptr[IW-1:0]] <= push_data;
   end

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PTRW'(DEPTH));
   p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush && pop_cnt == '0) |=> full);
   p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0));
endmodule

// File: rtl/lvu_pick.sv
module lvu_pick #(
   parameter int LANES = 8,
   parameter int PORTS = 4,
   localparam int CW = $clog2(LANES + 1),
   localparam int BW = $clog2(PORTS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANES-1:0]         need_two,
   input  logic [CW-1:0]            avail,
   output logic [CW-1:0]            take_cnt,
   output logic [LANES-1:0][BW-1:0] base
);
   logic [BW-1:0] used;

   always_comb begin
      int  spent;
      int  cost;
      logic stop;
      spent    = 0;
      stop     = 1'b0;
      take_cnt = '0;
      for (int i = 0; i < LANES; i++) begin
         cost    = need_two[i] ? 2 : 1;
         base[i] = BW'(spent);
         if (!stop && CW'(i) < avail && spent + cost <= PORTS) begin
            spent    = spent + cost;
            take_cnt = CW'(i + 1);
         end else begin
            stop = 1'b1;
         end
      end
      used = BW'(spent);
   end

   p_port_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
      used <= BW'(PORTS));
   p_take_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take_cnt <= avail);
endmodule

// File: rtl/lvu_lane.sv
module lvu_lane
   import lvu_pkg::*;
#(
   parameter int XLEN = 32,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic            exec,
   input  logic [OPW-1:0]  op,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [XLEN-1:0] pred,
   output logic [XLEN-1:0] value,
   output logic            match
);
   logic [XLEN-1:0] alu_out;

   always_comb begin
      unique case (alu_op_e'(op))
         OP_ADD:  alu_out = opa + opb;
         OP_SUB:  alu_out = opa - opb;
         OP_AND:  alu_out = opa & opb;
         OP_OR:   alu_out = opa | opb;
         OP_XOR:  alu_out = opa ^ opb;
         OP_LTU:  alu_out = XLEN'(opa < opb);
         OP_SHL:  alu_out = opa << opb[SHW-1:0];
         default: alu_out = opb;
      endcase
   end

   assign value = exec ? alu_out : opa;
   assign match = (value == pred);
endmodule

// File: rtl/late_validate_unit.sv
module late_validate_unit
   import lvu_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int AREG  = 7,
   parameter int TAGW  = 8,
   parameter int DEPTH = 32,
   parameter int LANES = 8,
   parameter int PORTS = 4,
   localparam int CW   = $clog2(LANES + 1),
   localparam int BW   = $clog2(PORTS + 1),
   localparam int PTRW = $clog2(DEPTH) + 1,
   localparam int EW   = 1 + OPW + 3 * AREG + XLEN + TAGW
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pred_valid,
   input  logic                      pred_exec,
   input  logic [OPW-1:0]            pred_op,
   input  logic [AREG-1:0]           pred_src_a,
   input  logic [AREG-1:0]           pred_src_b,
   input  logic [AREG-1:0]           pred_dst,
   input  logic [XLEN-1:0]           pred_value,
   input  logic [TAGW-1:0]           pred_tag,
   output logic                      pred_full,
   input  logic [CW-1:0]             rob_ready_cnt,
   output logic [PORTS-1:0][AREG-1:0] rf_raddr,
   input  logic [PORTS-1:0][XLEN-1:0] rf_rdata,
   output logic [LANES-1:0]          res_valid,
   output logic [LANES-1:0]          res_correct,
   output logic [LANES-1:0][XLEN-1:0] res_value,
   output logic [LANES-1:0][TAGW-1:0] res_tag,
   output logic                      squash_req,
   output logic [TAGW-1:0]           squash_tag
);
   generate
      if (PORTS < 2)
         $error("PORTS must allow one late-executed entry");
      if (DEPTH < LANES || (DEPTH & (DEPTH - 1)) != 0)
         $error("DEPTH must be a power of two no smaller than LANES");
      if (XLEN < 2 || (XLEN & (XLEN - 1)) != 0)
         $error("XLEN must be a power of two");
   endgenerate

   logic [LANES-1:0][EW-1:0]   win;
   logic [PTRW-1:0]            occ;
   logic [CW-1:0]              avail, take_cnt, commit_cnt, bad_idx;
   logic                       bad_hit;
   logic [LANES-1:0][BW-1:0]   base;
   logic [LANES-1:0]           w_exec, lane_ok;
   logic [LANES-1:0][OPW-1:0]  w_op;
   logic [LANES-1:0][AREG-1:0] w_sa, w_sb, w_dst;
   logic [LANES-1:0][XLEN-1:0] w_pred, opa, opb, lane_val;
   logic [LANES-1:0][TAGW-1:0] w_tag;

   lvu_fifo #(.WIDTH(EW), .DEPTH(DEPTH), .LANES(LANES)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (pred_valid),
      .push_data ({pred_exec, pred_op, pred_src_a, pred_src_b, pred_dst,
                   pred_value, pred_tag}),
      .pop_cnt   (commit_cnt),
      .flush     (bad_hit),
      .win       (win),
      .occ       (occ),
      .full      (pred_full)
   );

   always_comb begin
      logic [PTRW-1:0] lim;
      for (int i = 0; i < LANES; i++)
         {w_exec[i], w_op[i], w_sa[i], w_sb[i], w_dst[i], w_pred[i], w_tag[i]} = win[i];
      lim = occ;
      if (lim > PTRW'(LANES))            lim = PTRW'(LANES);
      if (PTRW'(rob_ready_cnt) < lim)    lim = PTRW'(rob_ready_cnt);
      avail = CW'(lim);
   end

   lvu_pick #(.LANES(LANES), .PORTS(PORTS)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .need_two (w_exec),
      .avail    (avail),
      .take_cnt (take_cnt),
      .base     (base)
   );

   // read-port steering: each taken lane owns one or two consecutive ports
   always_comb begin
      for (int p = 0; p < PORTS; p++) begin
         rf_raddr[p] = '0;
         for (int i = 0; i < LANES; i++) begin
            if (CW'(i) < take_cnt) begin
               if (base[i] == BW'(p))
                  rf_raddr[p] = w_exec[i] ? w_sa[i] : w_dst[i];
               if (w_exec[i] && base[i] + BW'(1) == BW'(p))
                  rf_raddr[p] = w_sb[i];
            end
         end
      end
   end

   always_comb begin
      int bi;
      for (int i = 0; i < LANES; i++) begin
         bi     = int'(base[i]);
         opa[i] = (bi < PORTS)     ? rf_rdata[bi]     : '0;
         opb[i] = (bi + 1 < PORTS) ? rf_rdata[bi + 1] : '0;
      end
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         lvu_lane #(.XLEN(XLEN)) u_lane (
            .exec  (w_exec[g]),
            .op    (w_op[g]),
            .opa   (opa[g]),
            .opb   (opb[g]),
            .pred  (w_pred[g]),
            .value (lane_val[g]),
            .match (lane_ok[g])
         );
      end
   endgenerate

   // oldest mismatch among taken lanes ends the group
   always_comb begin
      bad_hit = 1'b0;
      bad_idx = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (CW'(i) < take_cnt && !lane_ok[i]) begin
            bad_hit = 1'b1;
            bad_idx = CW'(i);
         end
      end
      commit_cnt = bad_hit ? bad_idx + CW'(1) : take_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= '0;
         res_correct <= '0;
         res_value   <= '0;
         res_tag     <= '0;
         squash_req  <= 1'b0;
         squash_tag  <= '0;
      end else begin
         for (int i = 0; i < LANES; i++) begin
            res_valid[i]   <= CW'(i) < commit_cnt;
            res_correct[i] <= (CW'(i) < commit_cnt) && lane_ok[i];
            res_value[i]   <= lane_val[i];
            res_tag[i]     <= w_tag[i];
         end
         squash_req <= bad_hit;
         squash_tag <= w_tag[bad_idx];
      end
   end

   generate
      for (genvar g = 1; g < LANES; g++) begin : g_prefix_chk
         p_lane_prefix_r10: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid[g] |-> res_valid[g-1]);
      end
   endgenerate

   p_squash_has_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squash_req |-> (|(res_valid & ~res_correct)));
   p_single_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(res_valid & ~res_correct) <= 1);
   p_miss_is_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(res_valid & ~res_correct)) |-> squash_req);
   p_no_full_after_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_hit |=> !pred_full);
endmodule

// File: tb/late_validate_unit_bench.sv
module late_validate_unit_bench;
   localparam int XLEN = 32, AREG = 7, TAGW = 8, DEPTH = 32, LANES = 8, PORTS = 4;
   localparam int CW = $clog2(LANES + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pred_valid = 1'b0, pred_exec = 1'b0;
   logic [2:0] pred_op = '0;
   logic [AREG-1:0] pred_src_a = '0, pred_src_b = '0, pred_dst = '0;
   logic [XLEN-1:0] pred_value = '0;
   logic [TAGW-1:0] pred_tag = '0;
   logic pred_full;
   logic [CW-1:0] rob_ready_cnt = '0;
   logic [PORTS-1:0][AREG-1:0] rf_raddr;
   logic [PORTS-1:0][XLEN-1:0] rf_rdata;
   logic [LANES-1:0] res_valid, res_correct;
   logic [LANES-1:0][XLEN-1:0] res_value;
   logic [LANES-1:0][TAGW-1:0] res_tag;
   logic squash_req;
   logic [TAGW-1:0] squash_tag;

   always #2 clk = ~clk;

   late_validate_unit u_late_validate_unit (.*);

   typedef struct {
      bit              ex;
      logic [XLEN-1:0] val;
      bit              bad;
      logic [TAGW-1:0] tag;
   } exp_t;
   exp_t q[$];

   int checks = 0, failures = 0, cur_rdy = 0, res_total = 0;
   bit mon_on = 1'b0, done = 1'b0;
   logic [TAGW-1:0] tag_ctr = 8'h10;

   function automatic logic [XLEN-1:0] reg_val(logic [AREG-1:0] r);
      return 32'h5A00_0000 ^ (32'(r) * 32'h0001_0193);
   endfunction

   function automatic logic [XLEN-1:0] ref_alu(logic [2:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return (a < b) ? 32'd1 : 32'd0;
         3'd6: return a << b[4:0];
         default: return b;
      endcase
   endfunction

   always_comb begin
      for (int p = 0; p < PORTS; p++) rf_rdata[p] = reg_val(rf_raddr[p]);
   end

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(bit ex, logic [2:0] op, int a, int b, int d, bit bad);
      logic [XLEN-1:0] v;
      v = ex ? ref_alu(op, reg_val(AREG'(a)), reg_val(AREG'(b))) : reg_val(AREG'(d));
      @(negedge clk);
      pred_valid = 1'b1; pred_exec = ex; pred_op = op;
      pred_src_a = AREG'(a); pred_src_b = AREG'(b); pred_dst = AREG'(d);
      pred_value = bad ? (v ^ 32'h0000_0100) : v;
      pred_tag   = tag_ctr;
      if (!pred_full) begin
         q.push_back('{ex, v, bad, tag_ctr});
         tag_ctr++;
      end
      @(posedge clk); #1 pred_valid = 1'b0;
   endtask

   task automatic set_rdy(int n);
      @(negedge clk);
      cur_rdy = n;
      rob_ready_cnt = CW'(n);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: greedy port-budget model plus in-order scoreboard
   always @(posedge clk) begin
      #1;
      if (mon_on && !done) begin
         int avail, g, used, cost, bad, expc, nv;
         logic [TAGW-1:0] bad_tag;
         exp_t it;
         avail = (q.size() < cur_rdy) ? q.size() : cur_rdy;
         if (avail > LANES) avail = LANES;
         g = 0; used = 0;
         for (int k = 0; k < avail; k++) begin
            cost = q[k].ex ? 2 : 1;
            if (used + cost > PORTS) break;
            used += cost; g++;
         end
         bad = -1;
         for (int k = 0; k < g; k++) if (q[k].bad) begin bad = k; break; end
         expc = (bad >= 0) ? bad + 1 : g;
         nv = $countones(res_valid);
         chk(nv == expc, "R3 R4 lane count", 64'(nv), 64'(expc));
         bad_tag = '0;
         for (int k = 0; k < nv; k++) begin
            res_total++;
            if (q.size() == 0) begin
               chk(1'b0, "R9 R10 unexpected result", 64'(res_tag[k]), 64'hFFFF);
            end else begin
               it = q.pop_front();
               chk(res_tag[k] == it.tag, "R2 order", 64'(res_tag[k]), 64'(it.tag));
               chk(res_value[k] == it.val, it.ex ? "R5 late exec value" : "R6 read-back value",
                   64'(res_value[k]), 64'(it.val));
               chk(res_correct[k] == !it.bad, "R7 correct flag", 64'(res_correct[k]), 64'(!it.bad));
               if (it.bad) bad_tag = it.tag;
            end
         end
         chk(squash_req == (bad >= 0), "R8 squash request", 64'(squash_req), 64'(bad >= 0));
         if (bad >= 0) begin
            chk(squash_tag == bad_tag, "R8 squash tag", 64'(squash_tag), 64'(bad_tag));
            q.delete();
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL R10 watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int snap;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pred_full == 1'b0, "R11 full after reset", 64'(pred_full), 0);
      chk(res_valid == '0, "R11 no lanes after reset", 64'(res_valid), 0);
      chk(squash_req == 1'b0, "R11 no squash after reset", 64'(squash_req), 0);
      mon_on = 1'b1;

      // check-only entries: four per cycle
      for (int k = 0; k < 8; k++) push(1'b0, 3'd0, 0, 0, k + 3, 1'b0);
      set_rdy(8);
      chk(res_valid == '0, "R10 nothing before the edge", 64'(res_valid), 0);
      idle(5);

      // late-executed entries, every operation
      set_rdy(0);
      for (int k = 0; k < 8; k++) push(1'b1, 3'(k), 20 + k, 40 + 3 * k, 0, 1'b0);
      push(1'b1, 3'd5, 50, 10, 0, 1'b0);
      push(1'b1, 3'd6, 9, 33, 0, 1'b0);
      set_rdy(8);
      idle(8);

      // mixed costs, retirement limit 3
      set_rdy(0);
      for (int k = 0; k < 9; k++) push(k % 3 == 1, 3'(k), k + 1, k + 60, k + 90, 1'b0);
      set_rdy(3);
      idle(8);

      // retirement limit 1
      set_rdy(0);
      for (int k = 0; k < 4; k++) push(k % 2 == 0, 3'd4, k, k + 7, k + 11, 1'b0);
      set_rdy(1);
      idle(7);

      // check-only mispredict in the middle of a group
      set_rdy(0);
      for (int k = 0; k < 6; k++) push(1'b0, 3'd0, 0, 0, 30 + k, k == 2);
      snap = res_total;
      set_rdy(8);
      idle(6);
      chk(res_total - snap == 3, "R8 R9 lanes up to the miss only", 64'(res_total - snap), 3);

      // late-exec mispredict
      set_rdy(0);
      push(1'b0, 3'd0, 0, 0, 5, 1'b0);
      push(1'b1, 3'd1, 70, 71, 0, 1'b1);
      push(1'b0, 3'd0, 0, 0, 6, 1'b0);
      set_rdy(8);
      idle(5);

      // fill to capacity
      set_rdy(0);
      for (int k = 0; k < DEPTH; k++) push(1'b0, 3'd0, 0, 0, k, 1'b0);
      @(negedge clk);
      chk(pred_full == 1'b1, "R1 full at depth", 64'(pred_full), 1);
      push(1'b0, 3'd0, 0, 0, 99, 1'b0);
      @(negedge clk);
      chk(pred_full == 1'b1, "R1 still full after refused push", 64'(pred_full), 1);
      snap = res_total;
      set_rdy(8);
      idle(12);
      chk(res_total - snap == DEPTH, "R1 refused push not stored", 64'(res_total - snap), 64'(DEPTH));
      chk(pred_full == 1'b0, "R1 full clears", 64'(pred_full), 0);

      // squash and push in the same cycle
      set_rdy(0);
      push(1'b0, 3'd0, 0, 0, 12, 1'b1);
      push(1'b0, 3'd0, 0, 0, 13, 1'b0);
      push(1'b1, 3'd0, 1, 2, 0, 1'b0);
      snap = res_total;
      @(negedge clk);
      cur_rdy = 1; rob_ready_cnt = CW'(1);
      pred_valid = 1'b1; pred_exec = 1'b0; pred_dst = 7'd14;
      pred_value = reg_val(7'd14); pred_tag = 8'hEE;
      @(negedge clk);
      pred_valid = 1'b0;
      cur_rdy = 8; rob_ready_cnt = CW'(8);
      idle(6);
      chk(res_total - snap == 1, "R9 flushed and dropped entries absent", 64'(res_total - snap), 1);
      chk(pred_full == 1'b0, "R9 queue empty after squash", 64'(pred_full), 0);

      idle(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule